// File: doc/BRIEF.md
# Quad-Word Burst Display RAM Writer

This block sits between a host parallel write port and a display RAM that is four words wide. In burst mode it gathers four 18-bit host words in a fill buffer. It then hands them, packed into one 72-bit line, to a commit buffer that holds a write request to the RAM until the RAM returns a done pulse. Because the fill buffer is free again as soon as the hand-off happens, the host can go on writing the next group while the previous commit is still running.

A group address counter gives each commit its base address. The counter moves by four word positions per group, upward or downward as the direction input selects. Inside the line, each lane holds the word for address base plus the lane number. For that reason the arrival order is mapped onto the lanes in reverse when the counter runs downward. The host only has to wait when a completed group cannot move because the commit buffer is still occupied. A busy output covers every pending commit, so the host knows when it may leave burst mode safely. A group cut short by leaving burst mode is dropped, and this is recorded in a sticky flag.

Top module: `burst_ram_writer`

## Requirements
- R1: After synchronous reset, ram_req, busy, wr_stall and partial_flag are 0, and a commit made without any address load uses base 0000h.
- R2: Four accepted words form one commit. With increment direction (dir_dec=0), the word that arrives in position i (0..3) of the group sits in ram_data bits [18i+17:18i]. If no commit is pending, ram_req is 1 in the cycle after the clock edge that accepted the fourth word.
- R3: With decrement direction (dir_dec=1), the word that arrives in position i sits in lane 3-i, which is bits [18(3-i)+17:18(3-i)].
- R4: ram_addr always has its low two bits at 0. The base of each group differs from the base of the previous group by +4 (increment) or -4 (decrement), modulo 2^16.
- R5: A pulse on load_addr takes start_addr with its low two bits dropped. The next group commits at that aligned base.
- R6: While ram_req is 1 and ram_done has not come, ram_addr and ram_data hold steady. ram_req falls only after a ram_done, and only if no further group is waiting.
- R7: The host can supply four more words while a commit is pending, with no stall. If a group completes while the commit buffer is still full, wr_stall is 1 until that buffer frees, and no word is accepted while wr_stall is 1. No word is lost.
- R8: busy is 1 whenever a commit is pending or a completed group is waiting. It falls in the cycle after the final ram_done.
- R9: A word presented while burst_en is 0 is ignored. It is neither stored nor counted.
- R10: If burst_en falls with one to three words of a group gathered, those words are discarded and partial_flag is set and stays set until reset. The next group starts again from its first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_en | input | 1 | Burst mode active |
| dir_dec | input | 1 | 1 = group address counts down, 0 = counts up |
| load_addr | input | 1 | Load pulse for the group address counter |
| start_addr | input | 16 | Start address; low two bits ignored |
| wr_valid | input | 1 | Host word strobe |
| wr_data | input | 18 | Host word |
| wr_stall | output | 1 | Host must hold its word |
| ram_req | output | 1 | Wide RAM write request |
| ram_addr | output | 16 | Aligned group base address |
| ram_data | output | 72 | Packed four-word line |
| ram_done | input | 1 | Single-cycle completion from the RAM |
| busy | output | 1 | Commit pending or group waiting |
| partial_flag | output | 1 | Sticky: an incomplete group was dropped |

## Verification
ram_req is due one edge after the fourth word is accepted. ram_req and busy drop one edge after the final ram_done, and partial_flag rises one edge after burst_en falls. The bench drives and samples on the falling clock edge, so each check reads the value settled after exactly that many rising edges. The RAM model latency is swept over 0, 2 and 9 cycles. The first two are short enough that a back-to-back host never stalls, while 9 forces a stall, and the bench predicts which case applies from the latency alone. Expected bases and packed lines are computed arithmetically from the start address, the direction and a word-value formula.

// File: rtl/bw_pkg.sv
package bw_pkg;
    localparam int WORD_W = 18;
    localparam int GRP_N  = 4;
    localparam int ADDR_W = 16;
    localparam int LANE_W = $clog2(GRP_N);
    localparam int LINE_W = WORD_W * GRP_N;

    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [LINE_W-1:0]            line_t;
    typedef logic [ADDR_W-1:0]            addr_t;
    typedef logic [GRP_N-1:0][WORD_W-1:0] group_t;

    typedef struct packed {
        addr_t base;
        line_t data;
    } commit_t;

    // Arrival slot i goes to lane i counting up, lane GRP_N-1-i counting down.
    function automatic line_t pack_group(input group_t g, input logic dec);
        line_t l;
        l = '0;
        for (int i = 0; i < GRP_N; i++) begin
            if (dec) l[(GRP_N-1-i)*WORD_W +: WORD_W] = g[i];
            else     l[i*WORD_W +: WORD_W]           = g[i];
        end
        return l;
    endfunction

    function automatic addr_t align_base(input addr_t a);
        return {a[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    endfunction

    function automatic addr_t next_base(input addr_t a, input logic dec);
        return dec ? a - ADDR_W'(GRP_N) : a + ADDR_W'(GRP_N);
    endfunction
endpackage

// File: rtl/bw_collector.sv
module bw_collector
    import bw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   burst_en,
    input  logic   wr_valid,
    input  word_t  wr_data,
    input  logic   can_load,
    output logic   wr_stall,
    output logic   handoff,
    output group_t grp_out,
    output logic   grp_ready,
    output logic   partial_flag
);
    logic [LANE_W-1:0] cnt;
    group_t            fill;
    logic              acc;
    logic              last;

    assign acc      = burst_en && wr_valid && !grp_ready;
    assign last     = acc && (cnt == LANE_W'(GRP_N-1));
    assign handoff  = (last || grp_ready) && can_load;
    assign wr_stall = grp_ready;

    always_comb begin
        grp_out = fill;
        if (last) grp_out[GRP_N-1] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            fill         <= '0;
            grp_ready    <= 1'b0;
            partial_flag <= 1'b0;
        end else begin
            if (acc) begin
                fill[cnt] <= wr_data;
                cnt       <= last ? '0 : cnt + LANE_W'(1);
            end
            if (last && !can_load)
                grp_ready <= 1'b1;
            else if (grp_ready && can_load)
                grp_ready <= 1'b0;
            if (!burst_en && cnt != '0) begin
                cnt          <= '0;
                partial_flag <= 1'b1;
            end
        end
    end

    // R7
    grp_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        grp_ready |-> cnt == '0);

    // R10
    partial_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(partial_flag) |-> $past(!burst_en));
endmodule

// File: rtl/bw_addr_ctr.sv
module bw_addr_ctr
    import bw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_addr,
    input  addr_t start_addr,
    input  logic  dir_dec,
    input  logic  step,
    output addr_t base
);
    always_ff @(posedge clk) begin
        if (rst)            base <= '0;
        else if (load_addr) base <= align_base(start_addr);
        else if (step)      base <= next_base(base, dir_dec);
    end
endmodule

// File: rtl/bw_commit.sv
module bw_commit
    import bw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  handoff,
    input  addr_t base_in,
    input  line_t line_in,
    input  logic  ram_done,
    output logic  can_load,
    output logic  ram_req,
    output addr_t ram_addr,
    output line_t ram_data
);
    commit_t held;
    logic    full;

    assign can_load = !full || ram_done;
    assign ram_req  = full;
    assign ram_addr = held.base;
    assign ram_data = held.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (handoff) begin
            full      <= 1'b1;
            held.base <= base_in;
            held.data <= line_in;
        end else if (ram_done) begin
            full <= 1'b0;
        end
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_req && !ram_done) |=> (ram_req && $stable(ram_addr) && $stable(ram_data)));

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_req) |-> $past(ram_done));
endmodule

// File: rtl/burst_ram_writer.sv
module burst_ram_writer
    import bw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_en,
    input  logic              dir_dec,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_stall,
    output logic              ram_req,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [LINE_W-1:0] ram_data,
    input  logic              ram_done,
    output logic              busy,
    output logic              partial_flag
);
    logic   can_load;
    logic   handoff;
    logic   grp_ready;
    group_t grp;
    addr_t  base;
    line_t  line;

    assign line = pack_group(grp, dir_dec);
    assign busy = ram_req || grp_ready;

    bw_collector u_col (
        .clk(clk), .rst(rst), .burst_en(burst_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .can_load(can_load), .wr_stall(wr_stall),
        .handoff(handoff), .grp_out(grp), .grp_ready(grp_ready),
        .partial_flag(partial_flag)
    );

    bw_addr_ctr u_ac (
        .clk(clk), .rst(rst), .load_addr(load_addr), .start_addr(start_addr),
        .dir_dec(dir_dec), .step(handoff), .base(base)
    );

    bw_commit u_cm (
        .clk(clk), .rst(rst), .handoff(handoff), .base_in(base),
        .line_in(line), .ram_done(ram_done), .can_load(can_load),
        .ram_req(ram_req), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(ram_done));

    // R4
    base_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_req) |-> ram_addr[1:0] == 2'b00);
endmodule

// File: tb/tb_burst_ram_writer.sv
module tb_burst_ram_writer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        burst_en = 1'b0, dir_dec = 1'b0, load_addr = 1'b0;
    logic [15:0] start_addr = '0;
    logic        wr_valid = 1'b0;
    logic [17:0] wr_data = '0;
    logic        wr_stall, ram_req, busy, partial_flag;
    logic [15:0] ram_addr;
    logic [71:0] ram_data;
    logic        ram_done = 1'b0;

    int n_chk = 0, n_fail = 0;
    int lat = 0, n_rec = 0, done_cnt = 0, stall_cyc = 0;
    logic [15:0] rec_addr [0:15];
    logic [71:0] rec_data [0:15];

    always #4 clk = ~clk;

    burst_ram_writer dut (
        .clk(clk), .rst(rst), .burst_en(burst_en), .dir_dec(dir_dec),
        .load_addr(load_addr), .start_addr(start_addr), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_stall(wr_stall), .ram_req(ram_req),
        .ram_addr(ram_addr), .ram_data(ram_data), .ram_done(ram_done),
        .busy(busy), .partial_flag(partial_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // RAM model: records each commit, answers after lat cycles, checks R6 at done
    initial begin
        bit pending = 0;
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                pending = 0; ram_done = 1'b0;
            end else begin
                if (ram_done) begin ram_done = 1'b0; pending = 0; end
                if (!pending && ram_req) begin
                    rec_addr[n_rec % 16] = ram_addr;
                    rec_data[n_rec % 16] = ram_data;
                    n_rec++; pending = 1; wcnt = lat;
                end else if (pending) begin
                    if (wcnt == 0) begin
                        chk(ram_req && ram_addr == rec_addr[(n_rec-1)%16] && ram_data == rec_data[(n_rec-1)%16],
                            "R6 held request", {56'd0, ram_addr}, {56'd0, rec_addr[(n_rec-1)%16]});
                        ram_done = 1'b1; done_cnt++;
                    end else wcnt--;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    function automatic logic [17:0] wval(input int seed, input int k);
        return 18'((seed * 1237 + k * 4099 + 5) & 32'h3FFFF);
    endfunction

    function automatic logic [71:0] exp_line(input int seed, input int g, input bit dec);
        logic [71:0] l = '0;
        for (int i = 0; i < 4; i++) begin
            if (dec) l[(3-i)*18 +: 18] = wval(seed, 4*g + i);
            else     l[i*18 +: 18]     = wval(seed, 4*g + i);
        end
        return l;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; burst_en = 1'b0; wr_valid = 1'b0; load_addr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_rec = 0; done_cnt = 0; stall_cyc = 0;
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic put_word(input logic [17:0] d);
        wr_valid = 1'b1; wr_data = d;
        while (wr_stall) begin stall_cyc++; @(negedge clk); end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic load(input logic [15:0] s);
        load_addr = 1'b1; start_addr = s;
        @(negedge clk);
        load_addr = 1'b0;
    endtask

    task automatic run_burst(input bit dec, input int l, input bit do_load, input logic [15:0] s, input int seed);
        logic [15:0] b;
        do_reset();
        lat = l; dir_dec = dec;
        if (do_load) load(s);
        burst_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            put_word(wval(seed, k));
            if (k == 3) chk(ram_req == 1'b1, "R2 request timing", {71'd0, ram_req}, 72'd1);
        end
        chk(busy == 1'b1, "R8 busy while pending", {71'd0, busy}, 72'd1);
        wait (done_cnt == 3);
        @(posedge clk); @(negedge clk);
        chk(busy == 1'b0 && ram_req == 1'b0, "R8 busy drop after last done", {70'd0, busy, ram_req}, 72'd0);
        chk(n_rec == 3, "R2 commit count", 72'(n_rec), 72'd3);
        chk((stall_cyc > 0) == (l >= 3), "R7 stall only when commit outlasts refill",
            72'(stall_cyc), 72'(l >= 3));
        b = do_load ? {s[15:2], 2'b00} : 16'h0000; // R5 / R1
        for (int g = 0; g < 3; g++) begin
            chk(rec_addr[g] == b, dec ? "R4 R5 decrement base" : "R4 R5 increment base",
                {56'd0, rec_addr[g]}, {56'd0, b});
            chk(rec_data[g] == exp_line(seed, g, dec), dec ? "R3 lane order" : "R2 lane order",
                rec_data[g], exp_line(seed, g, dec));
            b = dec ? b - 16'd4 : b + 16'd4;
        end
        burst_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1
        chk(ram_req == 0 && busy == 0 && wr_stall == 0 && partial_flag == 0, "R1 reset state",
            {68'd0, ram_req, busy, wr_stall, partial_flag}, 72'd0);

        run_burst(1'b0, 0, 1'b0, 16'h0000, 1);  // R1 default base
        run_burst(1'b0, 2, 1'b1, 16'hFFF9, 2);  // wrap upward
        run_burst(1'b1, 9, 1'b1, 16'h0005, 3);  // wrap downward, stall
        run_burst(1'b1, 0, 1'b1, 16'h1236, 4);
        run_burst(1'b0, 9, 1'b1, 16'h0043, 5);
        run_burst(1'b1, 2, 1'b1, 16'h8000, 6);

        // R9 and R10
        do_reset();
        lat = 1; dir_dec = 1'b0;
        load(16'h0102);
        burst_en = 1'b0;
        for (int k = 0; k < 3; k++) put_word(wval(7, k));
        @(negedge clk);
        chk(partial_flag == 0 && ram_req == 0, "R9 words ignored outside burst",
            {70'd0, partial_flag, ram_req}, 72'd0);
        burst_en = 1'b1;
        put_word(wval(8, 0));
        put_word(wval(8, 1));
        burst_en = 1'b0;
        @(negedge clk);
        chk(partial_flag == 1 && ram_req == 0, "R10 partial group dropped",
            {70'd0, partial_flag, ram_req}, {70'd0, 2'b10});
        burst_en = 1'b1;
        for (int k = 0; k < 4; k++) put_word(wval(9, k));
        wait (done_cnt == 1);
        @(posedge clk); @(negedge clk);
        chk(n_rec == 1 && rec_addr[0] == 16'h0100, "R10 R9 next group base",
            {56'd0, rec_addr[0]}, {56'd0, 16'h0100});
        chk(rec_data[0] == exp_line(9, 0, 1'b0), "R10 R9 next group restarts at slot 0",
            rec_data[0], exp_line(9, 0, 1'b0));
        chk(partial_flag == 1, "R10 flag sticky", {71'd0, partial_flag}, 72'd1);
        burst_en = 1'b0;
        finish_up();
    end
endmodule